// File: doc/BRIEF.md
# Candidate Block Window Memory

This block keeps the N×N window of search-area pixels that forms the candidate block currently offered to a block-matching unit. Over one reference block it walks through all (2p+1)² candidate positions of a (2p+N)×(2p+N) search area. It takes in each search-area pixel exactly once, so one reference block consumes (2p+N)² accepted pixels in total.

Pixels arrive one word at a time on a port qualified by a valid strobe. Candidates are visited row by row. Inside a row the window slides one column to the right. At the end of a row it jumps back to the left edge of the next row. It never sweeps backwards. Columns and window slices seen one candidate row earlier are kept in a delay line of 2p+1 steps and a small save register, so every candidate after the first row costs a single new pixel. The only exception is the first candidate of a row, which needs N new pixels. After the last candidate the next accepted pixel starts the fill of the following reference block.

Top module: `cand_window_mem`

## Requirements
- R1: After reset, cand_ready is 0, cand_idx is 0 and disp_row reads −p.
- R2: The first N² accepted pixels of a reference block give search-area rows 0..N−1 and columns 0..N−1. They arrive column by column from left to right, each column from top to bottom. On the clock edge that accepts the last of them, the window becomes that block, cand_ready becomes 1, cand_idx becomes 0 and both displacements become −p.
- R3: In candidate row 0, each further candidate takes N accepted pixels: the new rightmost column, top to bottom. The window moves one column left and that column enters at the right.
- R4: In candidate rows 1..2p, every candidate except the leftmost takes one accepted pixel, which becomes the bottom-right element. The other elements of the new right column are the pixels one row lower in the same column of the candidate 2p+1 steps earlier.
- R5: After the candidate at column displacement +p, N accepted pixels give the new bottom row, left to right. The next candidate is the leftmost one of the next candidate row. Its upper N−1 rows are the lower N−1 rows of the previous leftmost candidate.
- R6: cand_idx counts candidates 0..(2p+1)²−1 in scan order, with cand_idx = (disp_row+p)·(2p+1) + (disp_col+p). disp_col runs −p..+p inside a row. disp_row starts at −p and rises by one at each row change.
- R7: A cycle with pix_valid low changes nothing: the window, cand_idx, the displacements and cand_ready all hold, whatever is on pix_data.
- R8: While the pixels of the next candidate are being collected, cand_ready stays 1 and the window keeps showing the current candidate. The window changes only on the edge that accepts the final pixel of the group.
- R9: After candidate (2p+1)²−1, the next accepted pixel is pixel 0 of the next reference block. cand_ready drops to 0 on the edge that accepts it, and a new fill as in R2 follows.
- R10: On win_pix, the element at window row r and column c (row 0 at the top, column 0 at the left) occupies bits [(r·N+c)·PIX_W +: PIX_W].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_valid | input | 1 | pix_data holds a search-area pixel to accept on this edge |
| pix_data | input | PIX_W | Search-area pixel word |
| win_pix | output | N·N·PIX_W | Current candidate window, packed as in R10 |
| cand_ready | output | 1 | The window holds a complete candidate |
| cand_idx | output | clog2((2p+1)²) | Scan index of the current candidate |
| disp_row | output | clog2(p+1)+1 | Vertical displacement, two's complement |
| disp_col | output | clog2(p+1)+1 | Horizontal displacement, two's complement |

## Verification
A wrong scan counter shows at once as a cand_idx or displacement mismatch on the cycle after the faulty step. A mistake in the delay line or the save register stays hidden for a whole candidate row. It shows up 2p+1 steps later, in the upper rows of the window in candidate row 1, so every window element is compared on every clock from the first row change onward. Collector misalignment shows up as a window update one pixel early or late. Gaps of differing patterns in pix_valid expose it as a window change during collection.

// File: rtl/cbw_pkg.sv
package cbw_pkg;

   // Kind of window movement performed when the current pixel group completes
   typedef enum logic [1:0] {
      STEP_FILL      = 2'd0,   // initial load, one column at a time
      STEP_SHIFT_COL = 2'd1,   // first candidate row: new right column
      STEP_SINGLE    = 2'd2,   // later rows: one new bottom-right pixel
      STEP_RETURN    = 2'd3    // jump to leftmost candidate of next row
   } step_e;

   typedef enum logic {
      PH_FILL = 1'b0,
      PH_SCAN = 1'b1
   } phase_e;

endpackage

// File: rtl/cbw_collect.sv
module cbw_collect
   import cbw_pkg::*;
#(
   parameter int N     = 3,
   parameter int PIX_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [PIX_W-1:0]   in_pix,
   input  logic               single,
   output logic               grp_last,
   output logic [N*PIX_W-1:0] grp_vec
);

   localparam int CNT_W = $clog2(N);
   localparam int STG   = N - 1;

   logic [PIX_W-1:0] stg [STG];
   logic [CNT_W-1:0] cnt;

   assign grp_last = in_valid && (single || (cnt == CNT_W'(N-1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         for (int k = 0; k < STG; k++) stg[k] <= '0;
      end else if (in_valid) begin
         cnt <= grp_last ? '0 : cnt + 1'b1;
         for (int k = 0; k < STG - 1; k++) stg[k] <= stg[k+1];
         stg[STG-1] <= in_pix;
      end
   end

   // Oldest staged pixel is element 0; the pixel on the port closes the group
   for (genvar c = 0; c < STG; c++) begin : g_vec
      assign grp_vec[c*PIX_W +: PIX_W] = stg[c];
   end
   assign grp_vec[STG*PIX_W +: PIX_W] = in_pix;

   // Single-pixel steps only start on a group boundary
   assert_group_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      single |-> (cnt == '0));

endmodule

// File: rtl/cbw_delay.sv
module cbw_delay #(
   parameter int DEPTH = 7,
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] stage [DEPTH];

   if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        stage[0] <= '0;
         else if (shift_en) stage[0] <= din;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) stage[k] <= '0;
         end else if (shift_en) begin
            stage[0] <= din;
            for (int k = 1; k < DEPTH; k++) stage[k] <= stage[k-1];
         end
      end
   end

   assign dout = stage[DEPTH-1];

endmodule

// File: rtl/cbw_scan.sv
module cbw_scan
   import cbw_pkg::*;
#(
   parameter int N = 3,
   parameter int P = 3
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 acc,
   input  logic                                 grp_last,
   output step_e                                step,
   output logic                                 cand_new,
   output logic                                 cand_ready,
   output logic [$clog2((2*P+1)*(2*P+1))-1:0]   cand_idx,
   output logic [$clog2(2*P+1)-1:0]             row,
   output logic [$clog2(2*P+1)-1:0]             col
);

   localparam int D     = 2*P + 1;
   localparam int NCAND = D*D;
   localparam int IDX_W = $clog2(NCAND);
   localparam int RW    = $clog2(D);
   localparam int FW    = $clog2(N);
   localparam int LAST  = NCAND - 1;

   phase_e           phase;
   logic [FW-1:0]    fill_col;
   logic             rdy;
   logic [RW-1:0]    row_q, col_q;
   logic [IDX_W-1:0] idx_q;

   always_comb begin
      if (phase == PH_FILL)         step = STEP_FILL;
      else if (col_q != RW'(D-1))   step = (row_q == '0) ? STEP_SHIFT_COL : STEP_SINGLE;
      else if (row_q != RW'(D-1))   step = STEP_RETURN;
      else                          step = STEP_FILL;
   end

   assign cand_new = grp_last && ((step != STEP_FILL) || (fill_col == FW'(N-1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_FILL;
         fill_col <= '0;
         rdy      <= 1'b0;
         row_q    <= '0;
         col_q    <= '0;
         idx_q    <= '0;
      end else if (grp_last) begin
         unique case (step)
            STEP_FILL: begin
               if (fill_col == FW'(N-1)) begin
                  phase    <= PH_SCAN;
                  fill_col <= '0;
                  rdy      <= 1'b1;
                  row_q    <= '0;
                  col_q    <= '0;
                  idx_q    <= '0;
               end else begin
                  phase    <= PH_FILL;
                  fill_col <= fill_col + 1'b1;
                  rdy      <= 1'b0;
               end
            end
            STEP_SHIFT_COL, STEP_SINGLE: begin
               col_q <= col_q + 1'b1;
               idx_q <= idx_q + 1'b1;
            end
            STEP_RETURN: begin
               row_q <= row_q + 1'b1;
               col_q <= '0;
               idx_q <= idx_q + 1'b1;
            end
         endcase
      end else if (acc && (step == STEP_FILL)) begin
         rdy <= 1'b0;
      end
   end

   assign cand_ready = rdy;
   assign cand_idx   = idx_q;
   assign row        = row_q;
   assign col        = col_q;

   // Index only advances by one or restarts at zero
   assert_idx_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(idx_q) |-> ((idx_q == $past(idx_q) + 1'b1) || (idx_q == '0)));

   // Index and position counters agree
   assert_idx_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q == (IDX_W'(row_q) * IDX_W'(D) + IDX_W'(col_q)));

   // A row change while scanning lands on the leftmost candidate
   assert_row_change_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && !$stable(row_q)) |-> (col_q == '0));

   // Nothing moves without an accepted pixel
   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> ($stable(idx_q) && $stable(rdy) && $stable(row_q) && $stable(col_q)));

   // Ready only drops when a new block starts after the last candidate
   assert_ready_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdy) |-> ($past(acc) && ($past(idx_q) == IDX_W'(LAST))));

   // Ready rises only with the first candidate
   assert_ready_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy) |-> (idx_q == '0));

endmodule

// File: rtl/cand_window_mem.sv
module cand_window_mem
   import cbw_pkg::*;
#(
   parameter int N     = 3,
   parameter int P     = 3,
   parameter int PIX_W = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                pix_valid,
   input  logic [PIX_W-1:0]                    pix_data,
   output logic [N*N*PIX_W-1:0]                win_pix,
   output logic                                cand_ready,
   output logic [$clog2((2*P+1)*(2*P+1))-1:0]  cand_idx,
   output logic [$clog2(P+1):0]                disp_row,
   output logic [$clog2(P+1):0]                disp_col
);

   localparam int D      = 2*P + 1;
   localparam int NCAND  = D*D;
   localparam int IDX_W  = $clog2(NCAND);
   localparam int RW     = $clog2(D);
   localparam int DISP_W = $clog2(P+1) + 1;
   localparam int WIN_W  = N*N*PIX_W;
   localparam int LOW_W  = (N-1)*PIX_W;        // lower N-1 rows of one column
   localparam int SAVE_W = (N-1)*(N-1)*PIX_W;  // lower-left corner kept for returns

   if (N < 2) begin : g_bad_n
      $error("cand_window_mem: N must be at least 2");
   end
   if (P < 1) begin : g_bad_p
      $error("cand_window_mem: P must be at least 1");
   end
   if (PIX_W < 1) begin : g_bad_w
      $error("cand_window_mem: PIX_W must be at least 1");
   end

   step_e             step;
   logic              grp_last;
   logic              cand_new;
   logic [N*PIX_W-1:0] grp;
   logic [RW-1:0]     row, col;

   logic [WIN_W-1:0]  win_q, win_d;
   logic [SAVE_W-1:0] save_q, save_d;
   logic [LOW_W-1:0]  dly_in, dly_out;

   cbw_collect #(.N(N), .PIX_W(PIX_W)) u_collect (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (pix_valid),
      .in_pix   (pix_data),
      .single   (step == STEP_SINGLE),
      .grp_last (grp_last),
      .grp_vec  (grp)
   );

   cbw_scan #(.N(N), .P(P)) u_scan (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc        (pix_valid),
      .grp_last   (grp_last),
      .step       (step),
      .cand_new   (cand_new),
      .cand_ready (cand_ready),
      .cand_idx   (cand_idx),
      .row        (row),
      .col        (col)
   );

   cbw_delay #(.DEPTH(D), .WIDTH(LOW_W)) u_delay (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (cand_new),
      .din      (dly_in),
      .dout     (dly_out)
   );

   // Next-window network, one cell at a time
   for (genvar r = 0; r < N; r++) begin : g_row
      for (genvar c = 0; c < N; c++) begin : g_col
         localparam int E = r*N + c;
         if (r < N-1 && c < N-1) begin : g_inner
            assign win_d[E*PIX_W +: PIX_W] = (step == STEP_RETURN)
               ? save_q[(r*(N-1)+c)*PIX_W +: PIX_W]
               : win_q[(E+1)*PIX_W +: PIX_W];
         end else if (r < N-1) begin : g_right
            assign win_d[E*PIX_W +: PIX_W] =
               (step == STEP_FILL || step == STEP_SHIFT_COL)
               ? grp[r*PIX_W +: PIX_W]
               : dly_out[r*PIX_W +: PIX_W];
         end else if (c < N-1) begin : g_bottom
            assign win_d[E*PIX_W +: PIX_W] = (step == STEP_RETURN)
               ? grp[c*PIX_W +: PIX_W]
               : win_q[(E+1)*PIX_W +: PIX_W];
         end else begin : g_corner
            assign win_d[E*PIX_W +: PIX_W] = grp[(N-1)*PIX_W +: PIX_W];
         end
      end
   end

   // Slices of the incoming candidate kept for the next candidate row
   for (genvar r = 0; r < N-1; r++) begin : g_keep
      assign dly_in[r*PIX_W +: PIX_W] = win_d[((r+1)*N + N-1)*PIX_W +: PIX_W];
      for (genvar c = 0; c < N-1; c++) begin : g_keep_col
         assign save_d[(r*(N-1)+c)*PIX_W +: PIX_W] = win_d[((r+1)*N + c)*PIX_W +: PIX_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         save_q <= '0;
      end else begin
         if (grp_last) win_q <= win_d;
         if (cand_new && (step == STEP_FILL || step == STEP_RETURN)) save_q <= save_d;
      end
   end

   assign win_pix  = win_q;
   assign disp_row = DISP_W'(row) - DISP_W'(P);
   assign disp_col = DISP_W'(col) - DISP_W'(P);

   // Idle cycles leave the window alone
   assert_win_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> $stable(win_q));

   // Partial groups leave the window alone
   assert_win_partial_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !grp_last) |=> $stable(win_q));

   // Row-0 steps move every column one place left
   assert_col_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_last && step == STEP_SHIFT_COL) |=>
         (win_q[0 +: PIX_W] == $past(win_q[PIX_W +: PIX_W])));

   // A single step puts the accepted pixel at the bottom-right corner
   assert_single_corner_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_last && step == STEP_SINGLE) |=>
         (win_q[(N*N-1)*PIX_W +: PIX_W] == $past(pix_data)));

endmodule

// File: tb/cand_window_mem_bench.sv
module cand_window_mem_bench;

   localparam int N      = 3;
   localparam int P      = 3;
   localparam int W      = 8;
   localparam int D      = 2*P + 1;
   localparam int NCAND  = D*D;
   localparam int SA     = 2*P + N;
   localparam int TOTAL  = SA*SA;
   localparam int IDX_W  = $clog2(NCAND);
   localparam int DISP_W = $clog2(P+1) + 1;
   localparam int NBLK   = 3;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 pix_valid = 1'b0;
   logic [W-1:0]         pix_data = '0;
   logic [N*N*W-1:0]     win_pix;
   logic                 cand_ready;
   logic [IDX_W-1:0]     cand_idx;
   logic [DISP_W-1:0]    disp_row, disp_col;

   cand_window_mem #(.N(N), .P(P), .PIX_W(W)) u_cand_window_mem (
      .clk        (clk),
      .rst_n      (rst_n),
      .pix_valid  (pix_valid),
      .pix_data   (pix_data),
      .win_pix    (win_pix),
      .cand_ready (cand_ready),
      .cand_idx   (cand_idx),
      .disp_row   (disp_row),
      .disp_col   (disp_col)
   );

   always #4 clk = ~clk;   // 125 MHz

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   int ys[TOTAL];
   int xs[TOTAL];

   // Reference model state
   int blk = 0;          // block of the pixels accepted so far
   int blk_n = 0;        // pixels accepted in that block
   int cur = -1;         // current candidate, -1 when none
   bit last_v = 1'b0;
   bit have_prev = 1'b0;
   logic [N*N*W-1:0] prev_win;

   function automatic int sa_val(int b, int y, int x);
      return (y*16 + x + b*5) & 255;
   endfunction

   function automatic int cum(int k);
      int a, b;
      a = k / D;
      b = k % D;
      if (a == 0) return N*N + b*N;
      return N*N + 2*P*N + (a-1)*(N + 2*P) + N + b;
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int elem(int r, int c);
      return int'(win_pix[(r*N+c)*W +: W]);
   endfunction

   task automatic compare();
      string tag;
      int a, b, act, exp;
      bit bad;
      check((blk > 0) ? "R9" : "R2", "cand_ready", int'(cand_ready), (cur >= 0) ? 1 : 0);
      if (cur >= 0) begin
         a = cur / D;
         b = cur % D;
         check("R6", "cand_idx", int'(cand_idx), cur);
         check("R6", "disp_row", $signed(disp_row), a - P);
         check("R6", "disp_col", $signed(disp_col), b - P);
         if (have_prev && !last_v)      tag = "R7";
         else if (blk_n != cum(cur))    tag = "R8";
         else if (cur == 0)             tag = "R2";
         else if (a == 0)               tag = "R3";
         else if (b == 0)               tag = "R5";
         else                           tag = "R4";
         bad = 1'b0;
         act = elem(0, 0);
         exp = sa_val(blk, a, b);
         for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
               if (!bad && elem(r, c) != sa_val(blk, a + r, b + c)) begin
                  bad = 1'b1;
                  act = elem(r, c);
                  exp = sa_val(blk, a + r, b + c);
               end
            end
         end
         check(tag, "window", act, exp);
         if (cur == 0 && blk_n == N*N) begin
            check("R10", "bits of row0 col0", int'(win_pix[W-1:0]), sa_val(blk, 0, 0));
            check("R10", "bits of last element", int'(win_pix[N*N*W-1 -: W]),
                  sa_val(blk, N-1, N-1));
         end
      end
      if (have_prev && !last_v)
         check("R7", "window hold on idle", (win_pix == prev_win) ? 1 : 0, 1);
   endtask

   initial begin
      int n;
      n = 0;
      for (int c = 0; c < N; c++)
         for (int r = 0; r < N; r++) begin ys[n] = r; xs[n] = c; n++; end
      for (int b = 1; b <= 2*P; b++)
         for (int r = 0; r < N; r++) begin ys[n] = r; xs[n] = b + N - 1; n++; end
      for (int a = 1; a <= 2*P; a++) begin
         for (int c = 0; c < N; c++) begin ys[n] = a + N - 1; xs[n] = c; n++; end
         for (int b = 1; b <= 2*P; b++) begin ys[n] = a + N - 1; xs[n] = b + N - 1; n++; end
      end
   end

   initial begin
      logic [15:0] lfsr;
      int cyc, nb, nn;
      bit v;
      lfsr = 16'hACE1;
      cyc = 0;
      repeat (3) @(negedge clk);
      check("R1", "cand_ready in reset", int'(cand_ready), 0);
      check("R1", "cand_idx in reset", int'(cand_idx), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "cand_ready after reset", int'(cand_ready), 0);
      check("R1", "cand_idx after reset", int'(cand_idx), 0);
      check("R1", "disp_row after reset", $signed(disp_row), -P);

      while (!(blk == NBLK-1 && blk_n == TOTAL)) begin
         compare();
         if (blk_n == TOTAL) begin nb = blk + 1; nn = 0; end
         else begin nb = blk; nn = blk_n; end
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (nb == 0)      v = 1'b1;
         else if (nb == 1) v = (cyc % 3) != 1;
         else              v = lfsr[0] | lfsr[3];
         pix_valid = v;
         pix_data  = v ? W'(sa_val(nb, ys[nn], xs[nn])) : W'(cyc*13 + 7);
         prev_win  = win_pix;
         have_prev = 1'b1;
         last_v    = v;
         if (v) begin
            if (blk_n == TOTAL) begin blk++; blk_n = 0; cur = -1; end
            blk_n++;
            if (cur + 1 < NCAND && cum(cur + 1) == blk_n) cur++;
         end
         @(negedge clk);
         cyc++;
      end
      for (int k = 0; k < 6; k++) begin
         compare();
         pix_valid = 1'b0;
         pix_data  = W'(k*31 + 3);
         prev_win  = win_pix;
         last_v    = 1'b0;
         @(negedge clk);
      end
      compare();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL R6 watchdog actual=%0d expected=%0d", 200000, 0);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule